// File: doc/BRIEF.md
# Operand Address Generator

This block forms the address of a memory operand for a 16-bit processor with segmented memory. It builds a 16-bit offset from up to three terms: a base pointer (BX or BP), an index pointer (SI or DI) and a displacement. The displacement may be absent, a short 8-bit value that is sign-extended, or a full 16-bit value. The offset wraps within a 64 KB segment. A segment register value is then shifted left by four bits and added to the offset to give a 20-bit physical address.

Choosing which terms take part covers every operand form: displacement alone (direct), a single pointer (register-indirect), base plus displacement, index plus displacement, and base plus index with or without a displacement. The segment defaults to the stack segment when BP is the base, and to the data segment otherwise. A valid override input replaces that default. A request is sampled on a clock edge. The results and a one-cycle valid strobe appear on the registered outputs in the following cycle.

Top module: `opnd_addr_gen`

## Requirements
- R1: `outValid` is high in the cycle after each cycle in which `reqValid` is high, and low after every cycle in which `reqValid` is low. Back-to-back requests give back-to-back valid cycles.
- R2: `effAddr` equals the sum of the enabled terms. The base term is added when `useBase`=1 and is BX for `baseSel`=0 or BP for `baseSel`=1. The index term is added when `useIndex`=1 and is SI for `idxSel`=0 or DI for `idxSel`=1. The displacement is added as selected by `dispKind`.
- R3: `dispKind` encoding: 0 adds no displacement; 1 adds `disp[7:0]` sign-extended to 16 bits; 2 and 3 add all 16 bits of `disp`.
- R4: Direct form: with `useBase`=0, `useIndex`=0 and `dispKind`=2, `effAddr` equals `disp`.
- R5: The offset sum wraps modulo 2^16 before the segment is added. For example, BX=FFF0h plus SI=0020h plus displacement 0010h gives 0020h.
- R6: `physAddr` = (segment << 4) + `effAddr`, taken modulo 2^20. For example, segment FFFFh with offset FFFFh gives 0FFEFh.
- R7: Without an override, the segment is SS when `useBase`=1 and `baseSel`=1 (BP), and DS otherwise. `segUsed` reports the segment used with the codes 0=ES, 1=CS, 2=SS, 3=DS.
- R8: When `segOvrValid`=1, the segment coded on `segOvrSel` (same codes as R7) is used, whatever the base register.
- R9: While no request is captured, `effAddr`, `physAddr` and `segUsed` keep their last values.
- R10: While `rstN` is low and after its release, `outValid`, `effAddr`, `physAddr` and `segUsed` read zero until the first request is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| useBase | input | 1 | Add a base pointer term |
| baseSel | input | 1 | Base pointer: 0=BX, 1=BP |
| useIndex | input | 1 | Add an index pointer term |
| idxSel | input | 1 | Index pointer: 0=SI, 1=DI |
| dispKind | input | 2 | Displacement kind: 0 none, 1 short, 2/3 long |
| disp | input | 16 | Displacement value |
| segOvrValid | input | 1 | Segment override present |
| segOvrSel | input | 2 | Override segment code: 0=ES, 1=CS, 2=SS, 3=DS |
| regBx | input | 16 | BX value |
| regBp | input | 16 | BP value |
| regSi | input | 16 | SI value |
| regDi | input | 16 | DI value |
| segCs | input | 16 | CS value |
| segDs | input | 16 | DS value |
| segEs | input | 16 | ES value |
| segSs | input | 16 | SS value |
| outValid | output | 1 | Result valid, one cycle per request |
| effAddr | output | 16 | Registered 16-bit offset |
| physAddr | output | 20 | Registered 20-bit physical address |
| segUsed | output | 2 | Code of the segment applied |

## Verification
Two rules can apply to the same request and give different answers. A BP-based request selects the stack segment by default. An override selects another segment. The bench drives BP-based forms with the override both set and clear, in directed cases and in random traffic, and judges the result through `segUsed` and `physAddr`. A second collision is offset wraparound meeting physical-address wraparound in one request. It is provoked with large pointer values and a segment of FFFFh, and judged against the R5 and R6 arithmetic.

// File: rtl/oag_pkg.sv
package oag_pkg;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } segCode_e;

  typedef enum logic [1:0] {
    DISP_NONE  = 2'd0,
    DISP_SHORT = 2'd1,
    DISP_LONG  = 2'd2,
    DISP_LONG2 = 2'd3
  } dispKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      load;
    logic      addBase;
    logic      baseIsBp;
    logic      addIndex;
    logic      indexIsDi;
    dispKind_e dispKind;
    segCode_e  segCode;
  } oagStrobes_t;

endpackage

// File: rtl/oag_ctrl.sv
module oag_ctrl
  import oag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        useBase,
  input  logic        baseSel,
  input  logic        useIndex,
  input  logic        idxSel,
  input  logic [1:0]  dispKind,
  input  logic        segOvrValid,
  input  logic [1:0]  segOvrSel,
  output oagStrobes_t strobes,
  output logic        outValid
);

  segCode_e defaultSeg;

  always_comb begin
    defaultSeg = (useBase && baseSel) ? SEG_SS : SEG_DS;
    strobes.load      = reqValid;
    strobes.addBase   = useBase;
    strobes.baseIsBp  = baseSel;
    strobes.addIndex  = useIndex;
    strobes.indexIsDi = idxSel;
    strobes.dispKind  = dispKind_e'(dispKind);
    strobes.segCode   = segOvrValid ? segCode_e'(segOvrSel) : defaultSeg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= reqValid;
  end

  // R1: valid follows each request by exactly one cycle
  p_valid_after_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> outValid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !outValid);

endmodule

// File: rtl/oag_datapath.sv
module oag_datapath
  import oag_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SHORT_W   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  oagStrobes_t                   strobes,
  input  logic [OFS_W-1:0]              disp,
  input  logic [OFS_W-1:0]              regBx,
  input  logic [OFS_W-1:0]              regBp,
  input  logic [OFS_W-1:0]              regSi,
  input  logic [OFS_W-1:0]              regDi,
  input  logic [OFS_W-1:0]              segCs,
  input  logic [OFS_W-1:0]              segDs,
  input  logic [OFS_W-1:0]              segEs,
  input  logic [OFS_W-1:0]              segSs,
  output logic [OFS_W-1:0]              eaQ,
  output logic [OFS_W+SEG_SHIFT-1:0]    paQ,
  output logic [1:0]                    segQ
);

  localparam int PA_W    = OFS_W + SEG_SHIFT;
  localparam int EXT_W   = OFS_W - SHORT_W;
  localparam int NUM_SEG = 4;

  logic [OFS_W-1:0] baseTerm, indexTerm, dispTerm, eaNext, segVal;
  logic [PA_W-1:0]  paNext;
  logic [OFS_W-1:0] segArr [NUM_SEG];

  assign segArr[SEG_ES] = segEs;
  assign segArr[SEG_CS] = segCs;
  assign segArr[SEG_SS] = segSs;
  assign segArr[SEG_DS] = segDs;

  always_comb begin
    baseTerm  = '0;
    indexTerm = '0;
    if (strobes.addBase)  baseTerm  = strobes.baseIsBp  ? regBp : regBx;
    if (strobes.addIndex) indexTerm = strobes.indexIsDi ? regDi : regSi;
    case (strobes.dispKind)
      DISP_NONE:  dispTerm = '0;
      DISP_SHORT: dispTerm = {{EXT_W{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
      default:    dispTerm = disp;
    endcase
    eaNext = baseTerm + indexTerm + dispTerm;
    segVal = segArr[strobes.segCode];
    paNext = {segVal, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, eaNext};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ  <= '0;
      paQ  <= '0;
      segQ <= '0;
    end else if (strobes.load) begin
      eaQ  <= eaNext;
      paQ  <= paNext;
      segQ <= strobes.segCode;
    end
  end

  // R9: results hold without a request
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(eaQ) && $stable(paQ) && $stable(segQ)));
  // R6: shifted segment leaves the low nibble of the offset untouched
  p_low_nibble_r6: assert property (@(posedge clk) disable iff (!rstN)
    paQ[SEG_SHIFT-1:0] == eaQ[SEG_SHIFT-1:0]);

endmodule

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen
  import oag_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int SHORT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       useBase,
  input  logic                       baseSel,
  input  logic                       useIndex,
  input  logic                       idxSel,
  input  logic [1:0]                 dispKind,
  input  logic [OFS_W-1:0]           disp,
  input  logic                       segOvrValid,
  input  logic [1:0]                 segOvrSel,
  input  logic [OFS_W-1:0]           regBx,
  input  logic [OFS_W-1:0]           regBp,
  input  logic [OFS_W-1:0]           regSi,
  input  logic [OFS_W-1:0]           regDi,
  input  logic [OFS_W-1:0]           segCs,
  input  logic [OFS_W-1:0]           segDs,
  input  logic [OFS_W-1:0]           segEs,
  input  logic [OFS_W-1:0]           segSs,
  output logic                       outValid,
  output logic [OFS_W-1:0]           effAddr,
  output logic [OFS_W+SEG_SHIFT-1:0] physAddr,
  output logic [1:0]                 segUsed
);

  oagStrobes_t strobes;

  oag_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .useBase(useBase), .baseSel(baseSel), .useIndex(useIndex), .idxSel(idxSel),
    .dispKind(dispKind), .segOvrValid(segOvrValid), .segOvrSel(segOvrSel),
    .strobes(strobes), .outValid(outValid)
  );

  oag_datapath #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT), .SHORT_W(SHORT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .disp(disp),
    .regBx(regBx), .regBp(regBp), .regSi(regSi), .regDi(regDi),
    .segCs(segCs), .segDs(segDs), .segEs(segEs), .segSs(segSs),
    .eaQ(effAddr), .paQ(physAddr), .segQ(segUsed)
  );

  // R4: direct form returns the displacement as offset
  p_direct_disp_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !useBase && !useIndex && dispKind == 2'd2) |=> effAddr == $past(disp));
  // R7: BP base without override lands in the stack segment
  p_bp_default_ss_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !segOvrValid && useBase && baseSel) |=> segUsed == 2'd2);
  // R8: override code is reported
  p_override_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && segOvrValid) |=> segUsed == $past(segOvrSel));

endmodule

// File: tb/sim_opnd_addr_gen.sv
module sim_opnd_addr_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, useBase = 1'b0, baseSel = 1'b0, useIndex = 1'b0, idxSel = 1'b0;
  logic [1:0]  dispKind = '0;
  logic [15:0] disp = '0;
  logic        segOvrValid = 1'b0;
  logic [1:0]  segOvrSel = '0;
  logic [15:0] regBx = '0, regBp = '0, regSi = '0, regDi = '0;
  logic [15:0] segCs = '0, segDs = '0, segEs = '0, segSs = '0;
  logic        outValid;
  logic [15:0] effAddr;
  logic [19:0] physAddr;
  logic [1:0]  segUsed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] expEa = '0;
  logic [19:0] expPa = '0;
  logic [1:0]  expSeg = '0;

  always #10 clk = ~clk;

  opnd_addr_gen u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .useBase(useBase), .baseSel(baseSel),
    .useIndex(useIndex), .idxSel(idxSel), .dispKind(dispKind), .disp(disp),
    .segOvrValid(segOvrValid), .segOvrSel(segOvrSel),
    .regBx(regBx), .regBp(regBp), .regSi(regSi), .regDi(regDi),
    .segCs(segCs), .segDs(segDs), .segEs(segEs), .segSs(segSs),
    .outValid(outValid), .effAddr(effAddr), .physAddr(physAddr), .segUsed(segUsed)
  );

  function automatic logic [15:0] modelEa(bit ub, bit bs, bit ui, bit is, logic [1:0] dk, logic [15:0] d);
    logic [15:0] s;
    s = 16'h0;
    if (ub) s = s + (bs ? regBp : regBx);
    if (ui) s = s + (is ? regDi : regSi);
    if (dk == 2'd1) s = s + {{8{d[7]}}, d[7:0]};
    else if (dk != 2'd0) s = s + d;
    return s;
  endfunction

  function automatic logic [1:0] modelSeg(bit ub, bit bs, bit ov, logic [1:0] os);
    if (ov) return os;
    return (ub && bs) ? 2'd2 : 2'd3;
  endfunction

  function automatic logic [19:0] modelPa(logic [1:0] sc, logic [15:0] ea);
    logic [15:0] sv;
    case (sc)
      2'd0: sv = segEs;
      2'd1: sv = segCs;
      2'd2: sv = segSs;
      default: sv = segDs;
    endcase
    return ({sv, 4'h0} + {4'h0, ea});
  endfunction

  task automatic checkOut(string tag, bit expV);
    checks++;
    if (outValid !== expV || effAddr !== expEa || physAddr !== expPa || segUsed !== expSeg) begin
      errors++;
      $display("FAIL %s valid=%0b/%0b ea=%h/%h pa=%h/%h seg=%0d/%0d", tag,
               outValid, expV, effAddr, expEa, physAddr, expPa, segUsed, expSeg);
    end
  endtask

  task automatic request(bit ub, bit bs, bit ui, bit is, logic [1:0] dk, logic [15:0] d,
                         bit ov, logic [1:0] os);
    reqValid = 1'b1; useBase = ub; baseSel = bs; useIndex = ui; idxSel = is;
    dispKind = dk; disp = d; segOvrValid = ov; segOvrSel = os;
    expEa  = modelEa(ub, bs, ui, is, dk, d);
    expSeg = modelSeg(ub, bs, ov, os);
    expPa  = modelPa(expSeg, expEa);
    @(negedge clk);
  endtask

  task automatic idle();
    reqValid = 1'b0;
    useBase = $urandom_range(1); baseSel = $urandom_range(1);
    disp = 16'($urandom); segOvrValid = $urandom_range(1);
    @(negedge clk);
  endtask

  task automatic randRegs();
    regBx = 16'($urandom); regBp = 16'($urandom); regSi = 16'($urandom); regDi = 16'($urandom);
    segCs = 16'($urandom); segDs = 16'($urandom); segEs = 16'($urandom); segSs = 16'($urandom);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    @(negedge clk);
    @(negedge clk);
    checkOut("R10 in reset", 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R10 after release", 1'b0);

    randRegs();
    request(0, 0, 0, 0, 2'd2, 16'h1234, 0, 2'd0);
    checkOut("R4 direct", 1'b1);

    request(1, 0, 0, 0, 2'd0, 16'hFFFF, 0, 2'd0);
    checkOut("R2 indirect BX", 1'b1);

    request(0, 0, 1, 0, 2'd0, 16'h0, 0, 2'd0);
    checkOut("R2 indirect SI", 1'b1);

    request(1, 1, 0, 0, 2'd0, 16'h0, 0, 2'd0);
    checkOut("R7 BP defaults to SS", 1'b1);

    regBx = 16'h0100;
    request(1, 0, 0, 0, 2'd1, 16'h5580, 0, 2'd0);
    checkOut("R3 short negative disp", 1'b1);

    request(0, 0, 1, 1, 2'd3, 16'h8001, 0, 2'd0);
    checkOut("R3 long disp code 3", 1'b1);

    regBx = 16'hFFF0; regSi = 16'h0020;
    request(1, 0, 1, 0, 2'd2, 16'h0010, 0, 2'd0);
    checkOut("R5 offset wrap", 1'b1);
    if (effAddr !== 16'h0020) begin
      errors++;
      $display("FAIL R5 literal ea=%h/0020", effAddr);
    end
    checks++;

    segDs = 16'hFFFF;
    request(0, 0, 0, 0, 2'd2, 16'hFFFF, 0, 2'd0);
    checkOut("R6 physical wrap", 1'b1);
    checks++;
    if (physAddr !== 20'h0FFEF) begin
      errors++;
      $display("FAIL R6 literal pa=%h/0ffef", physAddr);
    end

    regBp = 16'hFFFF; regDi = 16'h0002; segEs = 16'hFFFF;
    request(1, 1, 1, 1, 2'd1, 16'h00FF, 1, 2'd0);
    checkOut("R8 override beats BP default", 1'b1);

    request(1, 0, 1, 1, 2'd2, 16'h0042, 1, 2'd2);
    checkOut("R8 override to SS", 1'b1);

    idle();
    checkOut("R1 idle drops valid", 1'b0);
    idle();
    checkOut("R9 hold", 1'b0);

    for (int i = 0; i < 400; i++) begin
      if (($urandom % 8) == 0) randRegs();
      if (($urandom % 10) < 7) begin
        request($urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1),
                2'($urandom), 16'($urandom), (($urandom % 3) == 0), 2'($urandom));
        checkOut("R1 R2 R7 R8 random request", 1'b1);
      end else begin
        idle();
        checkOut("R9 random idle", 1'b0);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule